// File: doc/BRIEF.md
# Gated Timestamp Tick Generator and Counter

This block gives a data acquisition system one common time base. It produces a timestamp tick and counts it, so that several independent readout controllers stay aligned. By default the tick comes from dividing the system clock by four. A select input can switch to an external tick input instead, which is synchronized and edge-detected. A run-enable input gates every tick. While run-enable is low, nothing reaches the counter or the exported tick output.

A typical start-of-run sequence holds run-enable low and clears every counter in the system. Run-enable is then raised as the final step, so all counters fed by the same gated tick start in step. The gated tick is driven out so that counters in other crates can follow it. A host reads the count through a slice select. The count is returned as fixed-width slices, least significant slice first, each zero-extended onto the host data bus. Everything runs in the system clock domain. The counter advances on a one-cycle enable and uses no derived clock.

Top module: `tstamp_gate_ctr`

## Requirements
- R1: While reset is held and in the first cycle after it, the count is zero and `tick_out` is low.
- R2: With `src_ext_sel` = 0 and `run_en` high, the count advances by exactly one every 4 system cycles. The first advance happens at the 4th rising clock edge that samples `run_en` high.
- R3: With `src_ext_sel` = 1 and `run_en` high, each rising edge of `ext_tick_in` advances the count by exactly one, at the 3rd clock edge after the new level is applied. The internal divider has no effect in this mode.
- R4: While `run_en` is low, the count does not change and `tick_out` stays low, whatever happens on `ext_tick_in` or on the internal divider.
- R5: A `clear_req` sampled while `run_en` is low sets the count to zero at that clock edge.
- R6: A `clear_req` sampled while `run_en` is high is ignored. The count only keeps its value or advances by one.
- R7: `tick_out` is high for one cycle, exactly in the cycle after each clock edge at which the count advanced, and at no other time.
- R8: `rd_sel` = k+1 returns count bits [k*SLICE_W +: SLICE_W] in the low bits of `rd_data`, with all upper bits zero. This gives four 16-bit slices at selects 1 to 4 with the defaults. `rd_sel` = 0 and any select above the slice count return zero.
- R9: The count wraps from all ones to zero and carries on counting.
- R10: The divide phase restarts whenever `run_en` is low. After any stop, the first advance again comes at the 4th edge that samples `run_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Global run-enable; gates all ticks |
| src_ext_sel | input | 1 | 0 selects the internal divided tick, 1 selects the external tick |
| ext_tick_in | input | 1 | Asynchronous external timestamp clock |
| clear_req | input | 1 | Clear command; honoured only while `run_en` is low |
| rd_sel | input | $clog2(CNT_W/SLICE_W+1) | Slice select: k+1 reads slice k |
| rd_data | output | BUS_W | Selected count slice, zero-extended |
| tick_out | output | 1 | Gated tick exported to other counters |

## Verification
The checker assumes that `run_en`, `clear_req` and `src_ext_sel` are synchronous to `clk`. It also assumes that `ext_tick_in` holds each level for at least three system cycles, so that the synchronizer sees every edge. The bench changes every input one time unit after a rising edge. It drives the external tick with levels held four cycles or longer, and it changes the source select only while `run_en` is low.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
   typedef enum logic {
      TSG_SRC_INT = 1'b0,
      TSG_SRC_EXT = 1'b1
   } tsg_src_e;

   function automatic int tsg_num_slices(input int cnt_w, input int slice_w);
      return cnt_w / slice_w;
   endfunction
endpackage

// File: rtl/tsg_divider.sv
module tsg_divider #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   output logic tick
);
   localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("tsg_divider: DIV must be at least 2");
   end

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_en) begin
         phase_q <= '0;
      end else if (phase_q == PH_LAST) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + PH_W'(1);
      end
   end

   assign tick = run_en && (phase_q == PH_LAST);
endmodule

// File: rtl/tsg_ext_edge.sv
module tsg_ext_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_in,
   output logic pulse
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tsg_ext_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sync_q[i] <= 1'b0;
         end else if (i == 0) begin
            sync_q[i] <= ext_in;
         end else begin
            sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign pulse = sync_q[SYNC_STAGES-1] && !prev_q;
endmodule

// File: rtl/tsg_counter.sv
module tsg_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             clear_req,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             tick_out
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tsg_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= step;
         if (!run_en && clear_req) begin
            cnt_q <= '0;
         end else if (step) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign cnt      = cnt_q;
   assign tick_out = tick_q;
endmodule

// File: rtl/tsg_slice_rd.sv
module tsg_slice_rd #(
   parameter int CNT_W   = 64,
   parameter int SLICE_W = 16,
   parameter int BUS_W   = 24,
   parameter int SEL_W   = 3
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [BUS_W-1:0] rd_data
);
   localparam int N_SL = tsg_pkg::tsg_num_slices(CNT_W, SLICE_W);

   if (CNT_W % SLICE_W != 0) begin : g_bad_split
      $error("tsg_slice_rd: CNT_W must be a multiple of SLICE_W");
   end
   if (SLICE_W > BUS_W) begin : g_bad_bus
      $error("tsg_slice_rd: SLICE_W must not exceed BUS_W");
   end

   logic [N_SL-1:0][SLICE_W-1:0] slices;
   assign slices = cnt;

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < N_SL; k++) begin
         if (rd_sel == SEL_W'(k + 1)) begin
            rd_data = BUS_W'(slices[k]);
         end
      end
   end
endmodule

// File: rtl/tstamp_gate_ctr.sv
module tstamp_gate_ctr #(
   parameter int CNT_W       = 64,
   parameter int SLICE_W     = 16,
   parameter int BUS_W       = 24,
   parameter int DIV         = 4,
   parameter int SYNC_STAGES = 2,
   localparam int N_SL       = CNT_W / SLICE_W,
   localparam int SEL_W      = $clog2(N_SL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             src_ext_sel,
   input  logic             ext_tick_in,
   input  logic             clear_req,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [BUS_W-1:0] rd_data,
   output logic             tick_out
);
   import tsg_pkg::*;

   logic             int_tick;
   logic             ext_pulse;
   logic             step;
   logic [CNT_W-1:0] cnt_q;
   tsg_src_e         src;

   assign src = tsg_src_e'(src_ext_sel);

   tsg_divider #(.DIV(DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run_en(run_en),
      .tick  (int_tick)
   );

   tsg_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .ext_in(ext_tick_in),
      .pulse (ext_pulse)
   );

   always_comb begin
      unique case (src)
         TSG_SRC_EXT: step = run_en && ext_pulse;
         default:     step = run_en && int_tick;
      endcase
   end

   tsg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .clear_req(clear_req),
      .step     (step),
      .cnt      (cnt_q),
      .tick_out (tick_out)
   );

   tsg_slice_rd #(
      .CNT_W  (CNT_W),
      .SLICE_W(SLICE_W),
      .BUS_W  (BUS_W),
      .SEL_W  (SEL_W)
   ) u_rd (
      .cnt    (cnt_q),
      .rd_sel (rd_sel),
      .rd_data(rd_data)
   );
endmodule

// File: rtl/tstamp_gate_ctr_chk.sv
module tstamp_gate_ctr_chk #(
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             clear_req,
   input logic             tick_out,
   input logic [CNT_W-1:0] cnt
);
   // R4: a stopped counter with no clear holds its value
   a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !clear_req) |=> $stable(cnt));

   // R4: no exported tick follows a stopped cycle
   a_r4_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run_en) |-> !tick_out);

   // R5: a clear while stopped zeroes the count
   a_r5_clear_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && clear_req) |=> (cnt == '0));

   // R6: while running, the count only holds or steps by one, even with a clear
   a_r6_running_step: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))));

   // R7: the exported tick marks a one-step advance
   a_r7_tick_means_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick_out |-> (cnt == $past(cnt) + CNT_W'(1)));

   // R7: every advance while running is exported
   a_r7_step_means_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_en) && (cnt != $past(cnt))) |-> tick_out);
endmodule

bind tstamp_gate_ctr tstamp_gate_ctr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .clear_req(clear_req),
   .tick_out (tick_out),
   .cnt      (cnt_q)
);

// File: tb/tstamp_gate_ctr_test.sv
`timescale 1ns/100ps
module tstamp_gate_ctr_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 1'b0, src_ext_sel = 1'b0, ext_tick_in = 1'b0, clear_req = 1'b0;
   logic [2:0]  rd_sel = '0;
   logic [23:0] rd_data;
   logic        tick_out;

   logic        run_m = 1'b0;
   logic [2:0]  sel_m = '0;
   logic [23:0] data_m;
   logic        tick_m;

   logic        run_s = 1'b0;
   logic [0:0]  sel_s = '0;
   logic [23:0] data_s;
   logic        tick_s;

   int vectors = 0;
   int errors  = 0;

   always #2.5 clk = ~clk;

   tstamp_gate_ctr uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_ext_sel(src_ext_sel),
      .ext_tick_in(ext_tick_in), .clear_req(clear_req), .rd_sel(rd_sel),
      .rd_data(rd_data), .tick_out(tick_out));

   tstamp_gate_ctr #(.CNT_W(32), .SLICE_W(8)) uut_mid (
      .clk(clk), .rst_n(rst_n), .run_en(run_m), .src_ext_sel(1'b0),
      .ext_tick_in(1'b0), .clear_req(clear_req), .rd_sel(sel_m),
      .rd_data(data_m), .tick_out(tick_m));

   tstamp_gate_ctr #(.CNT_W(8), .SLICE_W(8)) uut_small (
      .clk(clk), .rst_n(rst_n), .run_en(run_s), .src_ext_sel(1'b0),
      .ext_tick_in(1'b0), .clear_req(clear_req), .rd_sel(sel_s),
      .rd_data(data_s), .tick_out(tick_s));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic read_count(output logic [63:0] v);
      v = '0;
      for (int k = 0; k < 4; k++) begin
         rd_sel = 3'(k + 1);
         #0.2;
         v[k*16 +: 16] = rd_data[15:0];
      end
      rd_sel = '0;
      #0.2;
   endtask

   task automatic pulse_clear();
      clear_req = 1'b1;
      step(1);
      clear_req = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] v;
      read_count(v);
      check("R1 count in reset", v, 64'd0);
      check("R1 tick in reset", {63'd0, tick_out}, 64'd0);
      rst_n = 1'b1;
      step(1);
      read_count(v);
      check("R1 count after reset", v, 64'd0);
      check("R1 tick after reset", {63'd0, tick_out}, 64'd0);
   endtask

   task automatic t_internal();
      logic [63:0] v;
      src_ext_sel = 1'b0;
      pulse_clear();
      run_en = 1'b1;
      step(3);
      read_count(v);
      check("R2 no advance before 4th edge", v, 64'd0);
      check("R7 tick low before advance", {63'd0, tick_out}, 64'd0);
      step(1);
      read_count(v);
      check("R2 first advance at 4th edge", v, 64'd1);
      check("R7 tick after advance", {63'd0, tick_out}, 64'd1);
      step(1);
      check("R7 tick lasts one cycle", {63'd0, tick_out}, 64'd0);
      step(39);
      read_count(v);
      check("R2 one advance per 4 cycles", v, 64'd11);
   endtask

   task automatic t_clear_running();
      logic [63:0] v0, v1;
      read_count(v0);
      pulse_clear();
      read_count(v1);
      check("R6 clear ignored while running", {63'd0, (v1 == v0) || (v1 == v0 + 1)}, 64'd1);
      check("R6 count kept nonzero", {63'd0, v1 != 0}, 64'd1);
   endtask

   task automatic t_gating();
      logic [63:0] v0, v1;
      int ticks = 0;
      run_en = 1'b0;
      step(1);
      read_count(v0);
      for (int i = 0; i < 20; i++) begin
         step(1);
         ticks += int'(tick_out);
      end
      read_count(v1);
      check("R4 count held with internal source", v1, v0);
      src_ext_sel = 1'b1;
      for (int e = 0; e < 3; e++) begin
         ext_tick_in = 1'b1;
         for (int i = 0; i < 4; i++) begin step(1); ticks += int'(tick_out); end
         ext_tick_in = 1'b0;
         for (int i = 0; i < 4; i++) begin step(1); ticks += int'(tick_out); end
      end
      read_count(v1);
      check("R4 count held with external edges", v1, v0);
      check("R4 tick_out stays low while stopped", 64'(ticks), 64'd0);
      src_ext_sel = 1'b0;
   endtask

   task automatic t_clear_stopped();
      logic [63:0] v;
      pulse_clear();
      read_count(v);
      check("R5 clear while stopped", v, 64'd0);
   endtask

   task automatic t_restart();
      logic [63:0] v;
      run_en = 1'b1;
      step(6);
      run_en = 1'b0;
      step(1);
      pulse_clear();
      run_en = 1'b1;
      step(3);
      read_count(v);
      check("R10 phase restarted, no early advance", v, 64'd0);
      step(1);
      read_count(v);
      check("R10 advance at 4th edge after restart", v, 64'd1);
      run_en = 1'b0;
      step(1);
   endtask

   task automatic t_external();
      logic [63:0] v;
      pulse_clear();
      src_ext_sel = 1'b1;
      step(2);
      run_en = 1'b1;
      step(20);
      read_count(v);
      check("R3 internal divider ignored in external mode", v, 64'd0);
      for (int e = 1; e <= 5; e++) begin
         ext_tick_in = 1'b1;
         step(2);
         read_count(v);
         check("R3 no advance before 3rd edge", v, 64'(e - 1));
         step(1);
         read_count(v);
         check("R3 advance at 3rd edge", v, 64'(e));
         step(2);
         ext_tick_in = 1'b0;
         step(5);
      end
      read_count(v);
      check("R3 one advance per external edge", v, 64'd5);
      run_en = 1'b0;
      step(1);
      src_ext_sel = 1'b0;
   endtask

   task automatic t_readout();
      run_m = 1'b1;
      step(1200);
      run_m = 1'b0;
      step(1);
      sel_m = 3'd1; #0.2;
      check("R8 slice 1 is least significant", 64'(data_m), 64'd44);
      sel_m = 3'd2; #0.2;
      check("R8 slice 2", 64'(data_m), 64'd1);
      sel_m = 3'd3; #0.2;
      check("R8 slice 3", 64'(data_m), 64'd0);
      for (int s = 5; s < 8; s++) begin
         sel_m = 3'(s); #0.2;
         check("R8 out-of-range select reads zero", 64'(data_m), 64'd0);
      end
      sel_m = 3'd0; #0.2;
      check("R8 select 0 reads zero", 64'(data_m), 64'd0);
      rd_sel = 3'd0; #0.2;
      check("R8 select 0 on default instance", 64'(rd_data), 64'd0);
      rd_sel = 3'd6; #0.2;
      check("R8 select 6 on default instance", 64'(rd_data), 64'd0);
      rd_sel = 3'd0;
   endtask

   task automatic t_wrap();
      sel_s = 1'b1;
      run_s = 1'b1;
      step(1020);
      check("R9 count at all ones", 64'(data_s), 64'd255);
      step(4);
      check("R9 wraps to zero", 64'(data_s), 64'd0);
      check("R9 tick on wrap", {63'd0, tick_s}, 64'd1);
      step(4);
      check("R9 counts on after wrap", 64'(data_s), 64'd1);
      run_s = 1'b0;
      step(1);
   endtask

   initial begin
      step(3);
      t_reset();
      t_internal();
      t_clear_running();
      t_gating();
      t_clear_stopped();
      t_restart();
      t_external();
      t_readout();
      t_wrap();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule